// File: doc/BRIEF.md
# Address-Latched Multicart Bank Mapper

This block is the bank controller of a multi-game cartridge for an 8-bit console. It watches CPU writes to the upper half of the 64 KB CPU address space. It takes its one control register from the bits of the write address and ignores the data bus. From the captured bits it derives two 16 KB program-ROM bank numbers and a nametable mirroring select. The lower program window at 0x8000–0xBFFF always uses an even bank. The upper window at 0xC000–0xFFFF uses the same bank pair with a low bit that the write address chooses.

For every CPU access the block forms a 19-bit ROM address covering 32 banks, which is 512 KB. On the video side it passes picture-bus accesses through to an unbanked 8 KB character RAM. It also selects which picture-bus line drives the console's internal video RAM bank select, and so sets the mirroring.

Top module: `mcm_bank_mapper`

## Requirements
- R1: On a rising clock edge where `cpu_wr` is 1 and `cpu_addr[15]` is 1, the register loads from the address. A write with `cpu_addr[15]` = 0 leaves the banks and the mirroring unchanged.
- R2: Captured address bit 7 drives `mirror_h`, with 0 meaning vertical and 1 meaning horizontal. `vram_a10` follows `ppu_addr[10]` when vertical and `ppu_addr[11]` when horizontal.
- R3: The lower window bank `bank_lo` equals {captured bits 4..1, 0}, so its bit 0 is always 0.
- R4: The upper window bank `bank_hi` equals {captured bits 4..1, captured bit 5}.
- R5: `prg_addr` = {bank, `cpu_addr[13:0]`}, where the bank is `bank_hi` when `cpu_addr[14]` = 1 and `bank_lo` otherwise. `prg_rd` = `cpu_rd` AND `cpu_addr[15]`.
- R6: While `rst_n` is 0 and after reset, both banks are 0 and the mirroring is vertical.
- R7: Cycles without a write to the upper half, including reads, do not change the banks or the mirroring.
- R8: `chr_addr` = `ppu_addr[12:0]`. `chr_rd` = `ppu_rd` AND NOT `ppu_addr[13]`, and `chr_we` = `ppu_wr` AND NOT `ppu_addr[13]`.
- R9: A write to 0x803E gives banks 30 and 31. A write to 0x8022 gives banks 2 and 3. A write to 0xFF41, whose bits lie only outside bits 7, 5 and 4..1, gives banks 0 and 0 with vertical mirroring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| prg_addr | output | 19 | Program ROM address |
| prg_rd | output | 1 | Program ROM read enable |
| bank_lo | output | 5 | Bank of the 0x8000 window |
| bank_hi | output | 5 | Bank of the 0xC000 window |
| mirror_h | output | 1 | 1 = horizontal mirroring |
| ppu_addr | input | 14 | Picture bus address |
| ppu_rd | input | 1 | Picture bus read strobe |
| ppu_wr | input | 1 | Picture bus write strobe |
| chr_addr | output | 13 | Character RAM address |
| chr_rd | output | 1 | Character RAM read enable |
| chr_we | output | 1 | Character RAM write enable |
| vram_a10 | output | 1 | Video RAM bank select line |

## Verification
The assertions assume that `cpu_wr` is a single-cycle-per-access strobe sampled at the clock edge. They also assume that `cpu_addr` is stable around that edge, so the address captured by the register is the one seen in the same cycle. The stimulus changes every input one time unit after a rising edge and holds it for the whole cycle. The write addresses cover both halves of the CPU space, and they include addresses whose bits lie only outside the captured fields. The read and write strobes on both buses may overlap in any pattern, because the block must not depend on them being exclusive.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
    localparam int CPU_AW     = 16;
    localparam int BANK_W     = 5;
    localparam int WIN_W      = 14;
    localparam int PRG_AW     = BANK_W + WIN_W;
    localparam int PPU_AW     = 14;
    localparam int CHR_AW     = 13;
    // positions inside the captured write address
    localparam int MIR_BIT    = 7;
    localparam int LSB_BIT    = 5;
    localparam int UPF_LSB    = 1;
    localparam int UPF_W      = BANK_W - 1;

    typedef struct packed {
        logic             mirror_h;
        logic [UPF_W-1:0] bank_up;
        logic             bank_lsb;
    } latch_t;
endpackage

// File: rtl/mcm_addr_latch.sv
module mcm_addr_latch
    import mcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_mirror,
    input  logic             ld_lsb,
    input  logic [UPF_W-1:0] ld_up,
    output latch_t           st_q
);
    latch_t st_d;

    always_comb begin
        st_d = st_q;
        if (ld_en) begin
            st_d.mirror_h = ld_mirror;
            st_d.bank_lsb = ld_lsb;
            st_d.bank_up  = ld_up;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mcm_prg_window.sv
module mcm_prg_window
    import mcm_pkg::*;
#(
    parameter int BW = BANK_W,
    parameter int WW = WIN_W,
    localparam int AW = BW + WW
) (
    input  latch_t        st,
    input  logic [WW-1:0] win_off,
    input  logic          win_sel,
    input  logic          cpu_top,
    input  logic          cpu_rd,
    output logic [BW-1:0] bank_lo,
    output logic [BW-1:0] bank_hi,
    output logic [AW-1:0] prg_addr,
    output logic          prg_rd
);
    logic [BW-1:0] bank_sel;

    always_comb begin
        bank_lo  = {st.bank_up, 1'b0};
        bank_hi  = {st.bank_up, st.bank_lsb};
        bank_sel = win_sel ? bank_hi : bank_lo;
        prg_addr = {bank_sel, win_off};
        prg_rd   = cpu_rd & cpu_top;
    end
endmodule

// File: rtl/mcm_chr_route.sv
module mcm_chr_route
    import mcm_pkg::*;
#(
    parameter int PW = PPU_AW,
    parameter int CW = CHR_AW
) (
    input  logic          mirror_h,
    input  logic [PW-1:0] ppu_addr,
    input  logic          ppu_rd,
    input  logic          ppu_wr,
    output logic [CW-1:0] chr_addr,
    output logic          chr_rd,
    output logic          chr_we,
    output logic          vram_a10
);
    logic in_chr;

    always_comb begin
        in_chr   = ~ppu_addr[PW-1];
        chr_addr = ppu_addr[CW-1:0];
        chr_rd   = ppu_rd & in_chr;
        chr_we   = ppu_wr & in_chr;
        vram_a10 = mirror_h ? ppu_addr[11] : ppu_addr[10];
    end
endmodule

// File: rtl/mcm_bank_mapper.sv
module mcm_bank_mapper
    import mcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_rd,
    output logic [BANK_W-1:0] bank_lo,
    output logic [BANK_W-1:0] bank_hi,
    output logic              mirror_h,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              ppu_rd,
    input  logic              ppu_wr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_rd,
    output logic              chr_we,
    output logic              vram_a10
);
    latch_t st_q;
    logic   ld_en;

    assign ld_en    = cpu_wr & cpu_addr[CPU_AW-1];
    assign mirror_h = st_q.mirror_h;

    mcm_addr_latch i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_mirror (cpu_addr[MIR_BIT]),
        .ld_lsb    (cpu_addr[LSB_BIT]),
        .ld_up     (cpu_addr[UPF_LSB +: UPF_W]),
        .st_q      (st_q)
    );

    mcm_prg_window #(.BW(BANK_W), .WW(WIN_W)) i_prg (
        .st       (st_q),
        .win_off  (cpu_addr[WIN_W-1:0]),
        .win_sel  (cpu_addr[WIN_W]),
        .cpu_top  (cpu_addr[CPU_AW-1]),
        .cpu_rd   (cpu_rd),
        .bank_lo  (bank_lo),
        .bank_hi  (bank_hi),
        .prg_addr (prg_addr),
        .prg_rd   (prg_rd)
    );

    mcm_chr_route #(.PW(PPU_AW), .CW(CHR_AW)) i_chr (
        .mirror_h (st_q.mirror_h),
        .ppu_addr (ppu_addr),
        .ppu_rd   (ppu_rd),
        .ppu_wr   (ppu_wr),
        .chr_addr (chr_addr),
        .chr_rd   (chr_rd),
        .chr_we   (chr_we),
        .vram_a10 (vram_a10)
    );

    AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> (mirror_h == $past(cpu_addr[7]))); // R2
    AST_LOW_WIN_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> (bank_lo == {$past(cpu_addr[4:1]), 1'b0})); // R3
    AST_HIGH_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> (bank_hi == {$past(cpu_addr[4:1]), $past(cpu_addr[5])})); // R4
    AST_LOW_HALF_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[15]) |=> ($stable(bank_lo) && $stable(bank_hi) && $stable(mirror_h))); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> ($stable(bank_lo) && $stable(bank_hi) && $stable(mirror_h))); // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> (bank_lo == '0 && bank_hi == '0 && !mirror_h)); // R6
endmodule

// File: tb/test_mcm_bank_mapper.sv
`timescale 1ns/100ps
module test_mcm_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        ppu_rd = 1'b0;
    logic        ppu_wr = 1'b0;
    logic [18:0] prg_addr;
    logic        prg_rd;
    logic [4:0]  bank_lo, bank_hi;
    logic        mirror_h;
    logic [12:0] chr_addr;
    logic        chr_rd, chr_we, vram_a10;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_lat = '0;   // reference model: last captured address

    always #2.5 clk = ~clk;

    mcm_bank_mapper i_mcm_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .prg_addr(prg_addr), .prg_rd(prg_rd), .bank_lo(bank_lo), .bank_hi(bank_hi),
        .mirror_h(mirror_h), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
        .chr_addr(chr_addr), .chr_rd(chr_rd), .chr_we(chr_we), .vram_a10(vram_a10)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_lat = '0;
        else if (cpu_wr && cpu_addr >= 16'h8000) m_lat = cpu_addr;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the reference model
    always @(negedge clk) begin
        int elo, ehi, ebank, ea10;
        elo   = m_lat & 16'h1E;
        ehi   = elo | ((m_lat >> 5) & 1);
        ebank = (cpu_addr & 16'h4000) != 0 ? ehi : elo;
        ea10  = m_lat[7] ? ppu_addr[11] : ppu_addr[10];
        chk(bank_lo == elo[4:0], "R3 bank_lo", bank_lo, elo);
        chk(bank_hi == ehi[4:0], "R4 bank_hi", bank_hi, ehi);
        chk(mirror_h == m_lat[7], "R2 mirror_h", mirror_h, m_lat[7]);
        chk(vram_a10 == ea10[0], "R2 vram_a10", vram_a10, ea10);
        chk(prg_addr == ebank * 16384 + (cpu_addr % 16384), "R5 prg_addr", prg_addr,
            ebank * 16384 + (cpu_addr % 16384));
        chk(prg_rd == (cpu_rd && cpu_addr >= 16'h8000), "R5 prg_rd", prg_rd,
            cpu_rd && cpu_addr >= 16'h8000);
        chk(chr_addr == ppu_addr % 8192, "R8 chr_addr", chr_addr, ppu_addr % 8192);
        chk(chr_rd == (ppu_rd && ppu_addr < 8192), "R8 chr_rd", chr_rd, ppu_rd && ppu_addr < 8192);
        chk(chr_we == (ppu_wr && ppu_addr < 8192), "R8 chr_we", chr_we, ppu_wr && ppu_addr < 8192);
    end

    task automatic cyc(input logic [15:0] a, input logic rd, input logic wr);
        @(posedge clk);
        #1;
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    endtask

    task automatic expect_state(input int lo, input int hi, input int mh, input string req);
        @(negedge clk);
        chk(bank_lo == lo[4:0], req, bank_lo, lo);
        chk(bank_hi == hi[4:0], req, bank_hi, hi);
        chk(mirror_h == mh[0], req, mirror_h, mh);
    endtask

    initial begin
        #10000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bank_lo == 0 && bank_hi == 0 && !mirror_h, "R6 in reset", {bank_lo, bank_hi, mirror_h}, 0);
        #1; rst_n = 1'b1;
        expect_state(0, 0, 0, "R6 after reset");

        cyc(16'h803E, 0, 1); cyc(16'h0000, 0, 0);
        expect_state(30, 31, 0, "R9 write 803E");
        cyc(16'h8022, 0, 1); cyc(16'h0000, 0, 0);
        expect_state(2, 3, 0, "R9 write 8022");
        cyc(16'h7FBE, 0, 1); cyc(16'h0000, 0, 0);
        expect_state(2, 3, 0, "R1 low-half write ignored");
        cyc(16'hC0BE, 1, 0); cyc(16'hFFFF, 1, 0); cyc(16'h0000, 0, 0);
        expect_state(2, 3, 0, "R7 reads hold state");
        cyc(16'hFFBE, 0, 1); cyc(16'h0000, 0, 0);
        expect_state(30, 31, 1, "R2 horizontal via bit 7");
        cyc(16'hFF41, 0, 1); cyc(16'h0000, 0, 0);
        expect_state(0, 0, 0, "R9 write FF41");
        cyc(16'hE020, 0, 1); cyc(16'hC123, 1, 0);
        @(negedge clk);
        chk(prg_addr == 19'h04123, "R5 upper window addr", prg_addr, 19'h04123);
        cyc(16'h8123, 1, 0);
        @(negedge clk);
        chk(prg_addr == 19'h00123, "R5 lower window addr", prg_addr, 19'h00123);

        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            #1;
            cpu_addr = 16'($urandom);
            cpu_rd   = 1'($urandom);
            cpu_wr   = ($urandom % 3) == 0;
            ppu_addr = 14'($urandom);
            ppu_rd   = 1'($urandom);
            ppu_wr   = 1'($urandom);
        end
        cyc(16'h0000, 0, 0);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule